// File: doc/BRIEF.md
# Event Interrupt Flags and Seconds Timer

This block collects five single-cycle event pulses from a packet modem's receive and transmit sides and from its own seconds timer. The five sources are a forward-channel sync event, a change of the base station's decode status, a change of its idle status, an empty transmit buffer, and timer expiry. Each pulse sets a sticky bit in an 8-bit flag register. The host reads that register to learn why it was interrupted, and the read clears every bit. A per-source enable mask decides which flags may pull the interrupt line low. One more mask bit controls the receive-side sources when the current block's syndrome is non-zero: while that bit is 0, such a block keeps the sync, decode and idle sources from interrupting the host.

The timer is an 8-bit one-shot counter of whole seconds. It is advanced by a one-cycle tick from an external prescaler. Writing a non-zero value starts it, and writing again while it runs restarts it. Writing zero stops it. When it reaches its end it raises the timer flag once and then stays idle. The interrupt pin is modelled as an open-drain driver: a low level together with an output enable.

Top module: `evt_irq_timer`

## Requirements
- R1: After reset every flag reads 0, `irq_oe` is 0, `irq_n` is 1 and the timer is stopped.
- R2: An event pulse sets its flag on the clock edge where it is sampled. The flag positions are: bit 7 sync, bit 6 decode change, bit 5 idle change, bit 4 transmit empty, bit 3 timer expiry. Bits 2 to 0 always read 0.
- R3: A flag stays set until the host reads. `flag_rdata` shows the flags as they were before the read. A `flag_rd` strobe clears all flags on that clock edge.
- R4: An event that arrives on the same edge as a read is kept set after the read.
- R5: A mask write takes `wdata[7:3]` as the source enables (same bit order as the flags) and `wdata[2]` as the error-gating enable. Bits 1:0 are ignored. The interrupt becomes active one cycle after some flag is set whose enable is 1. Enables at 0 block the interrupt but leave the flags unchanged.
- R6: While the error-gating enable is 0 and `blk_err` is 1, the sync, decode and idle flags do not drive the interrupt. The transmit and timer flags are not affected by this. While the error-gating enable is 1, `blk_err` has no effect.
- R7: While the interrupt is active, `irq_oe` is 1 and `irq_n` is 0. Otherwise `irq_oe` is 0 and `irq_n` is 1.
- R8: A timer write of N from 1 to 255 sets the timer flag on the edge that samples the N-th `sec_tick` after the write, and not before.
- R9: A timer write of 0 stops the timer, and no expiry follows.
- R10: After expiry the timer raises no further flag until it is written again.
- R11: A timer write while the timer is running reloads the count and restarts the countdown.
- R12: A `sec_tick` on the same edge as a timer write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_sync | input | 1 | Sync event pulse |
| ev_dec | input | 1 | Decode-status change pulse |
| ev_idle | input | 1 | Idle-status change pulse |
| ev_txe | input | 1 | Transmit buffer empty pulse |
| blk_err | input | 1 | Level: current block syndrome is non-zero |
| sec_tick | input | 1 | One-cycle pulse per second from the prescaler |
| tmr_wr | input | 1 | Timer register write strobe |
| mask_wr | input | 1 | Mask register write strobe |
| wdata | input | 8 | Write data for the timer and mask registers |
| flag_rd | input | 1 | Flag register read strobe (clears the flags) |
| flag_rdata | output | 8 | Flag register contents |
| irq_n | output | 1 | Interrupt request, active low |
| irq_oe | output | 1 | Drive enable for `irq_n` (0 means released) |

## Verification
A flag is due on the edge that samples its event pulse. The timer flag is due on the edge that samples the final tick. A mask or flag change reaches `irq_n` and `irq_oe` one edge later, because the interrupt driver is registered. The bench drives every input 1 ns after a rising edge. At each rising edge it advances its own model using the inputs that edge sampled, then compares the outputs 1 ns later. Each expected value is therefore due in exactly the cycle the requirements give. The model's interrupt term is computed from the flags and mask as they stood before the edge, which matches that one-cycle lag.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   // number of interrupt sources
   localparam int unsigned N_SRC = 5;

   // flag and mask bit positions; the host decodes these
   localparam int unsigned POS_SYNC = 7;
   localparam int unsigned POS_DEC  = 6;
   localparam int unsigned POS_IDLE = 5;
   localparam int unsigned POS_TXE  = 4;
   localparam int unsigned POS_TMR  = 3;
   localparam int unsigned POS_ERRG = 2;

   // source vector index (bit i of a source vector sits at POS_TMR + i)
   localparam int unsigned SRC_TMR  = 0;
   localparam int unsigned SRC_TXE  = 1;
   localparam int unsigned SRC_IDLE = 2;
   localparam int unsigned SRC_DEC  = 3;
   localparam int unsigned SRC_SYNC = 4;

   typedef logic [N_SRC-1:0] src_vec_t;

   // receive-side sources subject to error gating
   localparam src_vec_t RX_SRC = src_vec_t'(5'b11100);

   function automatic src_vec_t pack_src(input logic s_sync, input logic s_dec,
                                         input logic s_idle, input logic s_txe,
                                         input logic s_tmr);
      src_vec_t v;
      v           = '0;
      v[SRC_SYNC] = s_sync;
      v[SRC_DEC]  = s_dec;
      v[SRC_IDLE] = s_idle;
      v[SRC_TXE]  = s_txe;
      v[SRC_TMR]  = s_tmr;
      return v;
   endfunction
endpackage

// File: rtl/evt_irq_flag_bank.sv
module evt_irq_flag_bank #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] flags_o
);
   // one sticky cell per source; set beats clear
   for (genvar i = 0; i < N; i++) begin : g_cell
      logic cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q <= 1'b0;
         end else if (set_i[i]) begin
            cell_q <= 1'b1;
         end else if (clr_i) begin
            cell_q <= 1'b0;
         end
      end
      assign flags_o[i] = cell_q;
   end
endmodule

// File: rtl/evt_irq_sec_timer.sv
module evt_irq_sec_timer #(
   parameter int unsigned TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TMR_W-1:0] load_val_i,
   input  logic             tick_i,
   output logic             expire_o
);
   localparam logic [TMR_W-1:0] ONE  = TMR_W'(1);
   localparam logic [TMR_W-1:0] ZERO = '0;

   logic [TMR_W-1:0] cnt_q;
   logic             run_q;
   logic             last_tick;

   // the tick that takes the count from one to zero ends the run
   assign last_tick = run_q && tick_i && (cnt_q == ONE) && !load_i;
   assign expire_o  = last_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         run_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
         run_q <= (load_val_i != ZERO);
      end else if (run_q && tick_i) begin
         cnt_q <= cnt_q - ONE;
         if (cnt_q == ONE) begin
            run_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/evt_irq_gate.sv
module evt_irq_gate #(
   parameter int unsigned N       = 5,
   parameter bit          IRQ_REG = 1'b1,
   parameter logic [N-1:0] RX_SET = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags_i,
   input  logic [N-1:0] en_i,
   input  logic         errg_en_i,
   input  logic         blk_err_i,
   output logic         act_o
);
   logic [N-1:0] allow;
   logic         pend;

   // receive sources drop out when the block is in error and gating is off
   always_comb begin
      allow = en_i;
      if (!errg_en_i && blk_err_i) begin
         allow = en_i & ~RX_SET;
      end
   end

   assign pend = |(flags_i & allow);

   if (IRQ_REG) begin : g_reg
      logic act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_q <= 1'b0;
         end else begin
            act_q <= pend;
         end
      end
      assign act_o = act_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign act_o = pend;
   end
endmodule

// File: rtl/evt_irq_timer.sv
module evt_irq_timer
   import evt_irq_pkg::*;
#(
   parameter int unsigned REG_W   = 8,
   parameter int unsigned TMR_W   = 8,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_sync,
   input  logic             ev_dec,
   input  logic             ev_idle,
   input  logic             ev_txe,
   input  logic             blk_err,
   input  logic             sec_tick,
   input  logic             tmr_wr,
   input  logic             mask_wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             flag_rd,
   output logic [REG_W-1:0] flag_rdata,
   output logic             irq_n,
   output logic             irq_oe
);
   // elaboration-time parameter checks
   if (REG_W < POS_SYNC + 1) begin : g_bad_reg_w
      $error("REG_W too narrow for the flag layout");
   end
   if (TMR_W < 1 || TMR_W > REG_W) begin : g_bad_tmr_w
      $error("TMR_W must lie between 1 and REG_W");
   end

   src_vec_t flags;
   src_vec_t set_vec;
   src_vec_t en_q;
   logic     errg_q;
   logic     tmr_expire;
   logic     irq_act;

   // mask register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         errg_q <= 1'b0;
      end else if (mask_wr) begin
         en_q   <= wdata[POS_SYNC:POS_TMR];
         errg_q <= wdata[POS_ERRG];
      end
   end

   evt_irq_sec_timer #(
      .TMR_W (TMR_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_wr),
      .load_val_i (wdata[TMR_W-1:0]),
      .tick_i     (sec_tick),
      .expire_o   (tmr_expire)
   );

   assign set_vec = pack_src(ev_sync, ev_dec, ev_idle, ev_txe, tmr_expire);

   evt_irq_flag_bank #(
      .N (N_SRC)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .clr_i   (flag_rd),
      .flags_o (flags)
   );

   evt_irq_gate #(
      .N       (N_SRC),
      .IRQ_REG (IRQ_REG),
      .RX_SET  (RX_SRC)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags_i   (flags),
      .en_i      (en_q),
      .errg_en_i (errg_q),
      .blk_err_i (blk_err),
      .act_o     (irq_act)
   );

   // flag register image; unused low bits read zero
   always_comb begin
      flag_rdata                   = '0;
      flag_rdata[POS_SYNC:POS_TMR] = flags;
   end

   // open-drain style pin: drive low when active, release otherwise
   assign irq_oe = irq_act;
   assign irq_n  = !irq_act;
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
   parameter int unsigned REG_W   = 8,
   parameter bit          IRQ_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ev_sync,
   input logic             ev_dec,
   input logic             ev_idle,
   input logic             ev_txe,
   input logic             sec_tick,
   input logic             tmr_wr,
   input logic             flag_rd,
   input logic [REG_W-1:0] flag_rdata,
   input logic             irq_n,
   input logic             irq_oe
);
   AST_SYNC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ev_sync |=> flag_rdata[7]); // R2
   AST_TXE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ev_txe |=> flag_rdata[4]); // R2
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd && !ev_idle) |=> !flag_rdata[5]); // R3
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_rd && flag_rdata[7]) |=> flag_rdata[7]); // R3
   AST_READ_KEEPS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd && ev_dec) |=> flag_rdata[6]); // R4
   AST_OE_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      irq_oe |-> !irq_n); // R7
   AST_RELEASED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_oe |-> irq_n); // R7
   AST_TMR_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_rdata[3]) |-> ($past(sec_tick) && !$past(tmr_wr))); // R12

   if (IRQ_REG) begin : g_reg_chk
      AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         irq_oe |-> ($past(flag_rdata) != '0)); // R5
   end else begin : g_comb_chk
      AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         irq_oe |-> (flag_rdata != '0)); // R5
   end
endmodule

bind evt_irq_timer evt_irq_chk #(
   .REG_W   (REG_W),
   .IRQ_REG (IRQ_REG)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_sync    (ev_sync),
   .ev_dec     (ev_dec),
   .ev_idle    (ev_idle),
   .ev_txe     (ev_txe),
   .sec_tick   (sec_tick),
   .tmr_wr     (tmr_wr),
   .flag_rd    (flag_rd),
   .flag_rdata (flag_rdata),
   .irq_n      (irq_n),
   .irq_oe     (irq_oe)
);

// File: tb/evt_irq_timer_tb_top.sv
module evt_irq_timer_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n;
   logic       ev_sync, ev_dec, ev_idle, ev_txe, blk_err, sec_tick;
   logic       tmr_wr, mask_wr, flag_rd;
   logic [7:0] wdata;
   logic [7:0] flag_rdata;
   logic       irq_n, irq_oe;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic [7:0] m_flags;
   logic [4:0] m_en;
   logic       m_errg;
   logic [7:0] m_cnt;
   logic       m_run;
   logic       m_act;

   evt_irq_timer dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_sync    (ev_sync),
      .ev_dec     (ev_dec),
      .ev_idle    (ev_idle),
      .ev_txe     (ev_txe),
      .blk_err    (blk_err),
      .sec_tick   (sec_tick),
      .tmr_wr     (tmr_wr),
      .mask_wr    (mask_wr),
      .wdata      (wdata),
      .flag_rd    (flag_rd),
      .flag_rdata (flag_rdata),
      .irq_n      (irq_n),
      .irq_oe     (irq_oe)
   );

   function automatic logic pend_f(logic [7:0] f, logic [4:0] en, logic g, logic e);
      logic [4:0] s;
      s = f[7:3] & en;
      if (!g && e) s[4:2] = 3'b000;
      return |s;
   endfunction

   task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk1(string tag, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic clear_inputs();
      ev_sync = 0; ev_dec = 0; ev_idle = 0; ev_txe = 0;
      sec_tick = 0; tmr_wr = 0; mask_wr = 0; flag_rd = 0; wdata = '0;
   endtask

   // one clock: advance model with the sampled inputs, compare 1 ns later
   task automatic step(string tag);
      logic nxt_act, expire;
      @(posedge clk);
      nxt_act = pend_f(m_flags, m_en, m_errg, blk_err);
      expire  = m_run && sec_tick && (m_cnt == 8'd1) && !tmr_wr;
      if (tmr_wr) begin
         m_cnt = wdata;
         m_run = (wdata != 0);
      end else if (m_run && sec_tick) begin
         m_cnt = m_cnt - 8'd1;
         if (m_cnt == 0) m_run = 1'b0;
      end
      m_flags = (flag_rd ? 8'h00 : m_flags) |
                {ev_sync, ev_dec, ev_idle, ev_txe, expire, 3'b000};
      if (mask_wr) begin
         m_en   = wdata[7:3];
         m_errg = wdata[2];
      end
      m_act = nxt_act;
      #1;
      chk8({tag, " flags"}, flag_rdata, m_flags);
      chk1({tag, " irq_oe"}, irq_oe, m_act);
      chk1({tag, " irq_n"}, irq_n, !m_act);
      clear_inputs();
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic do_tick(string tag);
      sec_tick = 1; step(tag);
      idle(2, tag);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // watchdog
   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h1E55_0A7D));
      rst_n = 0; blk_err = 0;
      clear_inputs();
      m_flags = 0; m_en = 0; m_errg = 0; m_cnt = 0; m_run = 0; m_act = 0;
      repeat (3) @(posedge clk);
      #1;
      chk8("R1 reset flags", flag_rdata, 8'h00);
      chk1("R1 reset irq_oe", irq_oe, 1'b0);
      chk1("R1 reset irq_n", irq_n, 1'b1);
      rst_n = 1;
      idle(2, "R1 quiet");
      // R1: timer stopped, so ticks raise nothing
      do_tick("R1 no timer");
      chk1("R1 no expiry after reset", flag_rdata[3], 1'b0);

      // R2: each event to its own bit, low bits zero
      ev_sync = 1; step("R2 sync bit7");
      ev_dec  = 1; step("R2 dec bit6");
      ev_idle = 1; step("R2 idle bit5");
      ev_txe  = 1; step("R2 txe bit4");
      chk8("R2 all rx/tx bits", flag_rdata, 8'hF0);
      idle(2, "R3 hold");
      flag_rd = 1; step("R3 read clears");
      chk8("R3 cleared", flag_rdata, 8'h00);

      // R5: enable all sources, errg on
      mask_wr = 1; wdata = 8'hFC; step("R5 mask all");
      ev_txe = 1; step("R5 set txe");
      step("R5 irq due");
      chk1("R5 irq active", irq_oe, 1'b1);
      chk1("R7 pin low", irq_n, 1'b0);
      flag_rd = 1; step("R3 read");
      step("R7 release");
      chk1("R7 released", irq_oe, 1'b0);

      // R4: event on the read edge survives
      ev_idle = 1; step("R4 pre");
      ev_dec = 1; flag_rd = 1; step("R4 event during read");
      chk8("R4 dec kept idle cleared", flag_rdata, 8'h40);
      flag_rd = 1; step("R4 clear");

      // R5: masked flags latch but do not interrupt
      mask_wr = 1; wdata = 8'h03; step("R5 mask none, low bits ignored");
      ev_sync = 1; ev_txe = 1; step("R5 masked set");
      idle(2, "R5 masked no irq");
      chk1("R5 masked irq", irq_oe, 1'b0);
      chk8("R5 flags intact", flag_rdata, 8'h90);
      flag_rd = 1; step("R5 clear");

      // R6: error gating
      mask_wr = 1; wdata = 8'hF8; step("R6 gate off");
      blk_err = 1;
      ev_sync = 1; ev_dec = 1; ev_idle = 1; step("R6 rx events in error");
      idle(2, "R6 suppressed");
      chk1("R6 rx suppressed", irq_oe, 1'b0);
      ev_txe = 1; step("R6 txe");
      step("R6 txe passes");
      chk1("R6 txe not gated", irq_oe, 1'b1);
      flag_rd = 1; step("R6 clr");
      mask_wr = 1; wdata = 8'hFC; step("R6 gate on");
      ev_sync = 1; step("R6 sync with gate on");
      step("R6 gate on irq");
      chk1("R6 blk_err no effect", irq_oe, 1'b1);
      flag_rd = 1; step("R6 clr2");
      blk_err = 0;
      idle(2, "R6 settle");

      // R8: write 3, expiry on third tick
      tmr_wr = 1; wdata = 8'd3; step("R8 load");
      do_tick("R8 tick1");
      do_tick("R8 tick2");
      chk1("R8 not yet", flag_rdata[3], 1'b0);
      sec_tick = 1; step("R8 tick3");
      chk1("R8 expired", flag_rdata[3], 1'b1);
      flag_rd = 1; step("R10 clr");
      // R10: no repeat
      for (int i = 0; i < 4; i++) do_tick("R10 one shot");
      chk1("R10 silent", flag_rdata[3], 1'b0);

      // R9: write 0 stops a running timer
      tmr_wr = 1; wdata = 8'd2; step("R9 load");
      do_tick("R9 tick");
      tmr_wr = 1; wdata = 8'd0; step("R9 stop");
      for (int i = 0; i < 4; i++) do_tick("R9 stopped");
      chk1("R9 no expiry", flag_rdata[3], 1'b0);

      // R11: reload restarts
      tmr_wr = 1; wdata = 8'd4; step("R11 load4");
      do_tick("R11 t1");
      do_tick("R11 t2");
      do_tick("R11 t3");
      tmr_wr = 1; wdata = 8'd2; step("R11 reload2");
      do_tick("R11 after reload");
      chk1("R11 restarted", flag_rdata[3], 1'b0);
      sec_tick = 1; step("R11 expire");
      chk1("R11 expired", flag_rdata[3], 1'b1);
      flag_rd = 1; step("R11 clr");

      // R12: tick on the write edge is not counted
      tmr_wr = 1; wdata = 8'd1; sec_tick = 1; step("R12 load with tick");
      chk1("R12 no count", flag_rdata[3], 1'b0);
      sec_tick = 1; step("R12 first real tick");
      chk1("R12 expired", flag_rdata[3], 1'b1);
      flag_rd = 1; step("R12 clr");

      // R8 upper bound: 255 ticks
      tmr_wr = 1; wdata = 8'd255; step("R8 load255");
      for (int i = 0; i < 254; i++) begin
         sec_tick = 1; step("R8 long count");
      end
      chk1("R8 255 not yet", flag_rdata[3], 1'b0);
      sec_tick = 1; step("R8 255 expire");
      chk1("R8 255 expired", flag_rdata[3], 1'b1);
      flag_rd = 1; step("R8 clr");

      // constrained random mix, R2 R3 R4 R5 R6 R8
      for (int i = 0; i < 6000; i++) begin
         ev_sync  = ($urandom_range(0, 15) == 0);
         ev_dec   = ($urandom_range(0, 15) == 0);
         ev_idle  = ($urandom_range(0, 15) == 0);
         ev_txe   = ($urandom_range(0, 15) == 0);
         flag_rd  = ($urandom_range(0, 7) == 0);
         sec_tick = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 31) == 0) blk_err = ~blk_err;
         if ($urandom_range(0, 49) == 0) begin
            mask_wr = 1; wdata = 8'($urandom);
         end else if ($urandom_range(0, 39) == 0) begin
            tmr_wr = 1; wdata = 8'($urandom_range(0, 6));
         end
         step("R2 R5 R6 random");
      end

      summary();
      $finish;
   end
endmodule